// File: doc/BRIEF.md
# Square-Only Modular Exponentiation Sequencer

This block raises a base to a secret power modulo an odd modulus and never uses a two-operand multiplier. A product is formed from two squarings through the identity a·b = ((a+b)/2)² − ((a−b)/2)². The exponent is consumed from bit 0 upward. Three working registers are used: P (running power of the base), A (accumulator, which holds the result) and T (scratch). Each loop iteration runs the same four micro-operations in a fixed order: a modular add, a modular halve, a modular subtract and one modular square. In every iteration, operations that are not needed still run on real registers as dummies. The sequence of operation types therefore does not depend on the key, and every squaring looks like every other.

Each iteration has a step code s in 0..3. Before an iteration starts, s becomes e·(1 + (s mod 3)), where e is the current exponent bit. A 0 bit therefore takes one iteration in step 0. A 1 bit takes three iterations, in steps 1, 2 and 3. Only steps 0 and 3 move to the next exponent bit.

The step table is as follows:

- Step 0: P←P+P, T←P/2, P←P−T, then P←P².
- Step 1: T←A+P, T←T/2, A←P−A, then T←T².
- Step 2: P←T+P, A←A/2, P←P−T, then A←A².
- Step 3: P←P+P, P←P/2, A←T−A, then P←P².

Halving never branches. Both z and z+n are formed, one of them is chosen by bit 0 of z, and the choice is shifted right by one bit. Modular add and subtract each apply one correction by n through a mux. The squarer is an interleaved shift-add-reduce engine that takes exactly W cycles for any operand.

Top module: `sqa_modexp`

## Requirements
- R1: After reset, `done` and `busy` are 0 and `result` is 0.
- R2: For an odd `modulus` n ≥ 3, a `base` m < n and any K-bit `expo` d, the value on `result` during the `done` pulse equals m^d mod n.
- R3: An all-zero exponent gives a result of 1, including when the base is 0.
- R4: A 0 exponent bit runs one iteration in step 0. A 1 bit runs steps 1, 2 and 3 in that order, so step 2 is only ever entered from step 1, and step 3 only from step 2.
- R5: `done` rises exactly 1 + (W+6)·(K + 2·ones(d)) clock edges after the edge that accepts `start`. This count does not depend on m or n.
- R6: In every iteration, register P holds the same value after the add, halve and subtract micro-operations as it held before them, so all dummy operations chain through P.
- R7: Every squaring result is below n.
- R8: While busy, the three working registers all stay below n.
- R9: A `start` pulse while `busy` is 1 is ignored. The running job's operands, result and latency are unchanged.
- R10: `busy` is 1 from the edge that accepts `start` until the edge that raises `done`. `done` is a one-cycle pulse with `busy` at 0. `result` holds its value after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accepts a job when idle |
| modulus | input | W | Odd modulus n, at least 3 |
| base | input | W | Base m, below n |
| expo | input | K | Exponent d |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | W | m^d mod n, held until the next job ends |

## Verification
A wrong step code or a wrong operand selection corrupts A or P. The error then propagates through every later squaring, so the value on `result` is wrong at the next `done` pulse. This holds even when the corruption sits in a dummy operation, because the dummy chain is checked as P being restored before each square. A bit-advance or step-walk error changes the iteration count, and the exact latency check reports it at the same `done` pulse. Range and ordering faults are reported internally in the cycle they occur.

// File: rtl/sqa_pkg.sv
package sqa_pkg;

    typedef logic [1:0] ridx_t;   // 0 = P, 1 = A, 2 = T

    typedef enum logic [1:0] {AOP_ADD, AOP_SUB, AOP_HALF} aop_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_PICK, PH_ADD, PH_HALF, PH_SUB, PH_SQS, PH_SQW
    } phase_t;

    typedef struct packed {
        ridx_t add_d;
        ridx_t add_a;
        ridx_t add_b;
        ridx_t hlf_d;
        ridx_t hlf_s;
        ridx_t sub_d;
        ridx_t sub_a;
        ridx_t sub_b;
        ridx_t sq_r;
        logic  adv;
    } row_t;

    function automatic row_t op_row(input logic [1:0] st);
        row_t r;
        case (st)
            2'd0:    r = '{2'd0, 2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd2, 2'd0, 1'b1};
            2'd1:    r = '{2'd2, 2'd1, 2'd0, 2'd2, 2'd2, 2'd1, 2'd0, 2'd1, 2'd2, 1'b0};
            2'd2:    r = '{2'd0, 2'd2, 2'd0, 2'd1, 2'd1, 2'd0, 2'd0, 2'd2, 2'd1, 1'b0};
            default: r = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd1, 2'd0, 1'b1};
        endcase
        return r;
    endfunction

    function automatic logic [1:0] next_step(input logic [1:0] st, input logic ebit);
        logic [1:0] m3;
        m3 = (st == 2'd3) ? 2'd0 : st;
        return ebit ? (m3 + 2'd1) : 2'd0;
    endfunction

endpackage

// File: rtl/sqa_arith.sv
module sqa_arith #(
    parameter int W = 16
) (
    input  sqa_pkg::aop_t   op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [W-1:0]    n,
    output logic [W-1:0]    y
);
    import sqa_pkg::*;

    logic [W:0] sum, sum_c, dif, dif_c, zn, hsel;
    logic [W-1:0] add_y, sub_y, half_y;

    always_comb begin
        sum    = {1'b0, a} + {1'b0, b};
        sum_c  = sum - {1'b0, n};
        add_y  = (sum >= {1'b0, n}) ? sum_c[W-1:0] : sum[W-1:0];

        dif    = {1'b0, a} - {1'b0, b};
        dif_c  = dif + {1'b0, n};
        sub_y  = dif[W] ? dif_c[W-1:0] : dif[W-1:0];

        zn     = {1'b0, a} + {1'b0, n};
        hsel   = a[0] ? zn : {1'b0, a};
        half_y = hsel[W:1];

        case (op)
            AOP_ADD: y = add_y;
            AOP_SUB: y = sub_y;
            default: y = half_y;
        endcase
    end

endmodule

// File: rtl/sqa_modsq.sv
module sqa_modsq #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] n,
    input  logic [W-1:0] x,
    output logic         done,
    output logic [W-1:0] y
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  acc, xr;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    dbl, dred, sum, sred;
    logic [W-1:0]  addend, nxt;

    always_comb begin
        dbl    = {acc, 1'b0};
        dred   = (dbl >= {1'b0, n}) ? dbl - {1'b0, n} : dbl;
        addend = xr[cnt] ? xr : '0;
        sum    = {1'b0, dred[W-1:0]} + {1'b0, addend};
        sred   = (sum >= {1'b0, n}) ? sum - {1'b0, n} : sum;
        nxt    = sred[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            xr   <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !run) begin
                acc <= '0;
                xr  <= x;
                cnt <= CW'(W-1);
                run <= 1'b1;
            end else if (run) begin
                acc <= nxt;
                cnt <= cnt - 1'b1;
                if (cnt == '0) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign y = acc;

    // R7
    sq_below_mod_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (y < n));

    // R10
    sq_start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !run);

endmodule

// File: rtl/sqa_modexp.sv
module sqa_modexp #(
    parameter int W = 16,
    parameter int K = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] modulus,
    input  logic [W-1:0] base,
    input  logic [K-1:0] expo,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    import sqa_pkg::*;

    localparam int IW = $clog2(K + 1);

    phase_t        phase;
    logic [1:0]    step;
    logic [IW-1:0] idx;
    logic [K-1:0]  esh;
    logic [W-1:0]  mod_r;
    logic [W-1:0]  rf [3];
    row_t          row;

    aop_t          aop;
    logic [W-1:0]  alu_a, alu_b, alu_y, sq_y;
    logic          sq_done;
    logic          wr_en;
    ridx_t         wr_idx;
    logic [W-1:0]  wr_data;

    function automatic logic [W-1:0] rd(input ridx_t s);
        case (s)
            2'd0:    return rf[0];
            2'd1:    return rf[1];
            default: return rf[2];
        endcase
    endfunction

    always_comb begin
        row     = op_row(step);
        aop     = AOP_ADD;
        alu_a   = rd(row.add_a);
        alu_b   = rd(row.add_b);
        wr_en   = 1'b0;
        wr_idx  = row.add_d;
        wr_data = alu_y;
        case (phase)
            PH_ADD: wr_en = 1'b1;
            PH_HALF: begin
                aop    = AOP_HALF;
                alu_a  = rd(row.hlf_s);
                wr_en  = 1'b1;
                wr_idx = row.hlf_d;
            end
            PH_SUB: begin
                aop    = AOP_SUB;
                alu_a  = rd(row.sub_a);
                alu_b  = rd(row.sub_b);
                wr_en  = 1'b1;
                wr_idx = row.sub_d;
            end
            PH_SQW: begin
                wr_en   = sq_done;
                wr_idx  = row.sq_r;
                wr_data = sq_y;
            end
            default: ;
        endcase
    end

    sqa_arith #(.W(W)) u_arith (
        .op(aop), .a(alu_a), .b(alu_b), .n(mod_r), .y(alu_y)
    );

    sqa_modsq #(.W(W)) u_sq (
        .clk(clk), .rst(rst), .start(phase == PH_SQS), .n(mod_r),
        .x(rd(row.sq_r)), .done(sq_done), .y(sq_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            step   <= 2'd0;
            idx    <= '0;
            esh    <= '0;
            mod_r  <= '0;
            rf[0]  <= '0;
            rf[1]  <= '0;
            rf[2]  <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (wr_en) begin
                case (wr_idx)
                    2'd0:    rf[0] <= wr_data;
                    2'd1:    rf[1] <= wr_data;
                    default: rf[2] <= wr_data;
                endcase
            end
            case (phase)
                PH_IDLE: if (start) begin
                    mod_r <= modulus;
                    rf[0] <= base;
                    rf[1] <= W'(1);
                    rf[2] <= W'(1);
                    esh   <= expo;
                    idx   <= '0;
                    step  <= 2'd0;
                    phase <= PH_PICK;
                end
                PH_PICK: if (idx == IW'(K)) begin
                    result <= rf[1];
                    done   <= 1'b1;
                    phase  <= PH_IDLE;
                end else begin
                    step  <= next_step(step, esh[0]);
                    phase <= PH_ADD;
                end
                PH_ADD:  phase <= PH_HALF;
                PH_HALF: phase <= PH_SUB;
                PH_SUB:  phase <= PH_SQS;
                PH_SQS:  phase <= PH_SQW;
                PH_SQW: if (sq_done) begin
                    if (row.adv) begin
                        idx <= idx + 1'b1;
                        esh <= esh >> 1;
                    end
                    phase <= PH_PICK;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase != PH_IDLE);

    // R4
    step_two_order_chk: assert property (@(posedge clk) disable iff (rst)
        (step == 2'd2 && $past(step) != 2'd2) |-> ($past(step) == 2'd1));

    // R4
    step_three_order_chk: assert property (@(posedge clk) disable iff (rst)
        (step == 2'd3 && $past(step) != 2'd3) |-> ($past(step) == 2'd2));

    // R6
    dummy_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SQS) |-> (rf[0] == $past(rf[0], 3)));

    // R8
    regs_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && phase != PH_PICK) |-> (rf[0] < mod_r && rf[1] < mod_r && rf[2] < mod_r));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> $stable(mod_r));

endmodule

// File: tb/sqa_modexp_tb.sv
module sqa_modexp_tb;
    localparam int W = 16;
    localparam int K = 16;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 150000;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] modulus, base;
    logic [K-1:0] expo;
    logic         busy, done;
    logic [W-1:0] result;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit timed_out = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG) timed_out = 1'b1;
    end

    sqa_modexp #(.W(W), .K(K)) u_dut (
        .clk(clk), .rst(rst), .start(start), .modulus(modulus), .base(base),
        .expo(expo), .busy(busy), .done(done), .result(result)
    );

    function automatic longint unsigned mpow(longint unsigned m, longint unsigned d,
                                             longint unsigned n);
        longint unsigned r = 1 % n;
        longint unsigned b = m % n;
        for (int k = 0; k < K; k++) begin
            if (d[k]) r = (r * b) % n;
            b = (b * b) % n;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic launch(input [W-1:0] m, input [K-1:0] d, input [W-1:0] n);
        @(negedge clk);
        modulus = n; base = m; expo = d; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && !timed_out) begin
            @(posedge clk); @(negedge clk);
            lat++;
        end
    endtask

    function automatic int exp_lat(input [K-1:0] d);
        return 1 + (W + 6) * (K + 2 * $countones(d));
    endfunction

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; modulus = '0; base = '0; expo = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(result == '0, "R1", "result after reset", result, 0);
    endtask

    task automatic t_run(input [W-1:0] m, input [K-1:0] d, input [W-1:0] n,
                         input string req);
        int lat;
        longint unsigned e;
        e = mpow(m, d, n);
        launch(m, d, n);
        wait_done(lat);
        chk(result == W'(e), req, "result", result, e);
        chk(lat == exp_lat(d), "R5", "latency", lat, exp_lat(d));
    endtask

    task automatic t_busy_ignore();
        int lat;
        longint unsigned e;
        e = mpow(16'd1234, 16'hB00F, 16'd65521);
        launch(16'd1234, 16'hB00F, 16'd65521);
        lat = 0;
        repeat (40) begin @(posedge clk); @(negedge clk); lat++; end
        chk(busy == 1'b1, "R10", "busy mid-run", busy, 1);
        modulus = 16'd101; base = 16'd7; expo = 16'h0003; start = 1'b1;
        @(posedge clk); @(negedge clk); lat++;
        start = 1'b0;
        while (!done && !timed_out) begin @(posedge clk); @(negedge clk); lat++; end
        chk(result == W'(e), "R9", "result with ignored start", result, e);
        chk(lat == exp_lat(16'hB00F), "R9", "latency with ignored start",
            lat, exp_lat(16'hB00F));
    endtask

    task automatic t_handshake();
        int lat;
        logic [W-1:0] held;
        launch(16'd3, 16'h0005, 16'd1001);
        wait_done(lat);
        chk(busy == 1'b0, "R10", "busy during done", busy, 0);
        held = result;
        @(negedge clk);
        chk(done == 1'b0, "R10", "done width", done, 0);
        repeat (5) @(negedge clk);
        chk(result == held, "R10", "result held", result, held);
        chk(result == 16'd243, "R2", "3^5 mod 1001", result, 243);
    endtask

    initial begin
        t_reset();
        t_run(16'd0,     16'h0000, 16'd65521, "R3");
        t_run(16'd12345, 16'h0000, 16'd40001, "R3");
        t_run(16'd2,     16'hFFFF, 16'd65521, "R2");
        t_run(16'd65520, 16'hFFFF, 16'd65521, "R2");
        t_run(16'd777,   16'h0001, 16'd65535, "R2");
        t_run(16'd777,   16'h8000, 16'd65535, "R2");
        t_run(16'd4321,  16'hAAAA, 16'd50021, "R4");
        t_run(16'd4321,  16'h5555, 16'd50021, "R4");
        t_run(16'd0,     16'h1234, 16'd99,    "R2");
        t_run(16'd2,     16'h00FF, 16'd3,     "R2");
        t_run(16'd9999,  16'h1234, 16'd30011, "R2");
        t_busy_ignore();
        t_handshake();
        if (timed_out) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <%0d cycles", cycles, WATCHDOG);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule